// File: doc/BRIEF.md
# Fine Attribute Redirect Logic

This block sits between the picture processor's memory bus and the cartridge memories. It lets every 8x8 tile carry its own palette selection. Each tile fetch from the nametable region leaves two address bits behind, the fine column bit and the fine row bit. When the attribute byte for that tile is fetched next, the block recognises the attribute address pattern. It turns off the console's nametable RAM and serves the byte from CHR RAM instead. One of four 8 KiB CHR RAM banks supplies the byte, and the two captured bits choose which one.

Outside attribute reads, the two upper CHR RAM address lines carry a bank number that the CPU writes into a small register. That register answers anywhere in the CPU window from $6000 to $7FFF. Pattern fetches therefore see ordinary CPU-selected 8 KiB banking.

Top module: `attr_redirect`

## Requirements
- R1: After reset the CPU bank register and the captured tile bits are both zero, so a pattern fetch drives CHR A14..A13 = 00.
- R2: An access is an attribute fetch when PPU A13 = 1 and PPU A9..A6 = 1111. During such an access nametable RAM /OE is high and CHR RAM /OE is low.
- R3: An access with PPU A13 = 1 that is not an attribute fetch drives nametable RAM /OE low and CHR RAM /OE high.
- R4: An access with PPU A13 = 0 drives CHR RAM /OE low and nametable RAM /OE high, whatever A9..A6 hold.
- R5: Each clock edge that sees a nametable read (PPU /RD low, A13 = 1, not an attribute fetch) captures PPU A0 and PPU A5. During a later attribute read (/RD low), CHR A13 equals the captured A0 and CHR A14 equals the captured A5.
- R6: The captured bits are kept through pattern reads, attribute reads and idle cycles (/RD high). Only another nametable read replaces them.
- R7: Whenever no attribute read is in progress, including an attribute address with /RD high, CHR A14..A13 show the CPU bank register.
- R8: A clock edge with M2 high, CPU R/W low and a CPU address in $6000-$7FFF loads CPU data bits 1..0 into the bank register. Bit 0 drives CHR A13 and bit 1 drives CHR A14.
- R9: CPU reads, writes outside $6000-$7FFF and writes with M2 low leave the bank register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for both registers |
| rst_n | input | 1 | Active-low reset, clears both registers |
| ppu_addr | input | 14 | PPU address A13..A0 |
| ppu_rd_n | input | 1 | PPU read strobe, active low |
| cpu_addr | input | 16 | CPU address bus |
| cpu_data | input | 8 | CPU data bus |
| cpu_rw_n | input | 1 | CPU read/write, low for a write |
| cpu_m2 | input | 1 | CPU phase-2 qualifier |
| ntram_oe_n | output | 1 | Console nametable RAM output enable, active low |
| chrram_oe_n | output | 1 | CHR RAM output enable, active low |
| chr_bank_hi | output | 2 | CHR RAM address lines A14..A13 |

## Verification
The bench drives all four fine column and row combinations through a nametable read followed by an attribute read. A design that swaps A0 and A5, or that drops one of them, returns the wrong bank for at least one combination. Pattern reads and idle cycles are placed between the capture and the attribute read, and a capture that follows them would then lose the tile bits. An attribute address with /RD high must still show the CPU bank, because redirecting on the address alone would corrupt CPU-side CHR access. Writes at $5FFF and $8000, a CPU read and a write with M2 low check that the window and its qualifiers are decoded exactly.

// File: rtl/attr_redirect.sv
module attr_redirect #(
  parameter int PPU_AW  = 14,
  parameter int CPU_AW  = 16,
  parameter int CPU_DW  = 8,
  parameter int BANK_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PPU_AW-1:0] ppu_addr,
  input  logic              ppu_rd_n,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [CPU_DW-1:0] cpu_data,
  input  logic              cpu_rw_n,
  input  logic              cpu_m2,
  output logic              ntram_oe_n,
  output logic              chrram_oe_n,
  output logic [BANK_W-1:0] chr_bank_hi
);
  localparam int WIN_HI_BITS = 3;
  localparam logic [WIN_HI_BITS-1:0] WIN_TAG = 3'b011;

  logic              vram_sel;
  logic              attr_hit;
  logic              nt_read;
  logic              attr_read;
  logic              cpu_hit;
  logic [1:0]        fine_q;
  logic [BANK_W-1:0] bank_q;

  assign vram_sel  = ppu_addr[13];
  assign attr_hit  = vram_sel & (&ppu_addr[9:6]);
  assign nt_read   = ~ppu_rd_n & vram_sel & ~attr_hit;
  assign attr_read = ~ppu_rd_n & attr_hit;

  assign ntram_oe_n  = ~(vram_sel & ~attr_hit);
  assign chrram_oe_n = ~(~vram_sel | attr_hit);

  assign cpu_hit = cpu_m2 & ~cpu_rw_n &
                   (cpu_addr[CPU_AW-1 -: WIN_HI_BITS] == WIN_TAG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       fine_q <= '0;
    else if (nt_read) fine_q <= {ppu_addr[5], ppu_addr[0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bank_q <= '0;
    else if (cpu_hit) bank_q <= cpu_data[BANK_W-1:0];
  end

  assign chr_bank_hi = attr_read ? fine_q : bank_q;
endmodule

module attr_redirect_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [13:0] ppu_addr,
  input logic        ppu_rd_n,
  input logic [15:0] cpu_addr,
  input logic        cpu_rw_n,
  input logic        cpu_m2,
  input logic        ntram_oe_n,
  input logic        chrram_oe_n,
  input logic [1:0]  chr_bank_hi
);
  logic live;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) live <= 1'b0; else live <= 1'b1;

  logic is_attr, is_nt_rd, is_wr;
  assign is_attr  = ppu_addr[13] && ppu_addr[9:6] == 4'hF;
  assign is_nt_rd = !ppu_rd_n && ppu_addr[13] && !is_attr;
  assign is_wr    = cpu_m2 && !cpu_rw_n && cpu_addr >= 16'h6000 && cpu_addr <= 16'h7FFF;

  AST_ATTR_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    is_attr |-> (ntram_oe_n && !chrram_oe_n)); // R2
  AST_NT_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (ppu_addr[13] && !is_attr) |-> (!ntram_oe_n && chrram_oe_n)); // R3
  AST_PAT_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    !ppu_addr[13] |-> (!chrram_oe_n && ntram_oe_n)); // R4
  AST_FINE_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    (live && $past(is_nt_rd) && !ppu_rd_n && is_attr) |->
      chr_bank_hi == {$past(ppu_addr[5]), $past(ppu_addr[0])}); // R5
  AST_BANK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (live && !$past(is_wr) && !$past(!ppu_rd_n && is_attr) && !(!ppu_rd_n && is_attr))
      |-> $stable(chr_bank_hi)); // R9
endmodule

bind attr_redirect attr_redirect_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ppu_addr(ppu_addr), .ppu_rd_n(ppu_rd_n),
  .cpu_addr(cpu_addr), .cpu_rw_n(cpu_rw_n), .cpu_m2(cpu_m2),
  .ntram_oe_n(ntram_oe_n), .chrram_oe_n(chrram_oe_n), .chr_bank_hi(chr_bank_hi)
);

// File: tb/attr_redirect_tb.sv
module attr_redirect_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [13:0] ppu_addr = '0;
  logic        ppu_rd_n = 1'b1;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic        cpu_rw_n = 1'b1;
  logic        cpu_m2 = 1'b0;
  logic        ntram_oe_n, chrram_oe_n;
  logic [1:0]  chr_bank_hi;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  attr_redirect u_dut (
    .clk(clk), .rst_n(rst_n), .ppu_addr(ppu_addr), .ppu_rd_n(ppu_rd_n),
    .cpu_addr(cpu_addr), .cpu_data(cpu_data), .cpu_rw_n(cpu_rw_n), .cpu_m2(cpu_m2),
    .ntram_oe_n(ntram_oe_n), .chrram_oe_n(chrram_oe_n), .chr_bank_hi(chr_bank_hi)
  );

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic ppu_step(input logic [13:0] a, input logic rd_n);
    @(negedge clk);
    ppu_addr = a; ppu_rd_n = rd_n;
    @(posedge clk); #1;
  endtask

  task automatic cpu_step(input logic [15:0] a, input logic [7:0] d, input logic rw_n, input logic m2);
    @(negedge clk);
    cpu_addr = a; cpu_data = d; cpu_rw_n = rw_n; cpu_m2 = m2;
    @(posedge clk); #1;
    @(negedge clk);
    cpu_rw_n = 1'b1; cpu_m2 = 1'b0;
  endtask

  task automatic t_reset;
    ppu_step(14'h0000, 1'b0);
    check("R1 bank", {2'b0, chr_bank_hi}, 4'h0);
    ppu_step(14'h23C0, 1'b0);
    check("R1 fine", {2'b0, chr_bank_hi}, 4'h0);
  endtask

  task automatic t_decode;
    ppu_step(14'h23C0, 1'b1);
    check("R2 enables", {2'b0, ntram_oe_n, chrram_oe_n}, 4'b0010);
    ppu_step(14'h2FC5, 1'b0);
    check("R2 enables alt", {2'b0, ntram_oe_n, chrram_oe_n}, 4'b0010);
    ppu_step(14'h2345, 1'b0);
    check("R3 enables", {2'b0, ntram_oe_n, chrram_oe_n}, 4'b0001);
    ppu_step(14'h03C0, 1'b0);
    check("R4 enables", {2'b0, ntram_oe_n, chrram_oe_n}, 4'b0001 ^ 4'b0011);
  endtask

  task automatic t_redirect;
    for (int k = 0; k < 4; k++) begin
      logic [13:0] nt;
      nt = 14'h2000 | 14'(k[0]) | (14'(k[1]) << 5) | 14'h0042;
      ppu_step(nt, 1'b0);
      ppu_step(14'h23C1, 1'b0);
      check("R5 fine route", {2'b0, chr_bank_hi}, {2'b0, k[1], k[0]});
    end
  endtask

  task automatic t_hold;
    ppu_step(14'h2021, 1'b0);
    ppu_step(14'h0010, 1'b0);
    ppu_step(14'h1FFF, 1'b0);
    ppu_step(14'h2400, 1'b1);
    ppu_step(14'h27C0, 1'b0);
    ppu_step(14'h27C8, 1'b0);
    check("R6 hold", {2'b0, chr_bank_hi}, 4'h3);
  endtask

  task automatic t_cpu_bank;
    cpu_step(16'h6000, 8'hFE, 1'b0, 1'b1);
    ppu_step(14'h0100, 1'b0);
    check("R8 load 2", {2'b0, chr_bank_hi}, 4'h2);
    cpu_step(16'h7FFF, 8'h01, 1'b0, 1'b1);
    ppu_step(14'h0100, 1'b0);
    check("R8 load 1", {2'b0, chr_bank_hi}, 4'h1);
    ppu_step(14'h2000, 1'b0);
    ppu_step(14'h23C0, 1'b1);
    check("R7 attr no rd", {2'b0, chr_bank_hi}, 4'h1);
    ppu_step(14'h2400, 1'b0);
    check("R7 nametable", {2'b0, chr_bank_hi}, 4'h1);
  endtask

  task automatic t_cpu_ignored;
    cpu_step(16'h5FFF, 8'h03, 1'b0, 1'b1);
    ppu_step(14'h0000, 1'b1);
    check("R9 below window", {2'b0, chr_bank_hi}, 4'h1);
    cpu_step(16'h8000, 8'h03, 1'b0, 1'b1);
    ppu_step(14'h0000, 1'b1);
    check("R9 above window", {2'b0, chr_bank_hi}, 4'h1);
    cpu_step(16'h6800, 8'h03, 1'b1, 1'b1);
    ppu_step(14'h0000, 1'b1);
    check("R9 read", {2'b0, chr_bank_hi}, 4'h1);
    cpu_step(16'h6800, 8'h03, 1'b0, 1'b0);
    ppu_step(14'h0000, 1'b1);
    check("R9 m2 low", {2'b0, chr_bank_hi}, 4'h1);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        t_reset();
        t_decode();
        t_redirect();
        t_hold();
        t_cpu_bank();
        t_cpu_ignored();
      end
      begin
        repeat (5000) @(posedge clk);
        failures++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule